// File: doc/BRIEF.md
# Interrupt Entry Controller

This block carries out the entry sequence into an interrupt for a small 32-bit processor. At each instruction boundary it looks at the request lines: a reset request, one non-maskable request and six maskable sources. It picks the winner and computes the new program counter and status word. It also updates the cause register and records the interrupted context in one of two save pairs. The non-maskable request has its own save pair, so a non-maskable entry never destroys the context saved by a maskable one.

The surrounding pipeline supplies the running PC and status word together with a strobe that marks a completed instruction. All results are registered. In the cycle after an accepted boundary, a one-cycle redirect pulse tells the fetch stage to continue at the new PC and to load the new status word.

A non-maskable request can arrive while a non-maskable handler is still running, which the status word shows through its NMI-pending bit. In that case the request is stored in a single pending flag and is taken at a later boundary, once that bit is clear.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While `rst` is high, the block clears PC, cause register, all four save registers, the pending flag and the redirect pulse on the next clock edge, and it sets the status word to 0x20.
- R2: Requests are looked at only on edges where `insn_done` is 1. Each accepted entry raises `redirect` for exactly the one cycle that follows that edge.
- R3: Every accepted entry leaves the interrupt-disable bit (status bit 5) set and the exception-pending bit (status bit 6) clear in `new_psw`.
- R4: A reset request forces PC to 0, the status word to 0x20 and the cause register to 0. It leaves the save registers unchanged and discards a pending non-maskable request.
- R5: A non-maskable entry copies `cur_pc` and `cur_psw` into the non-maskable save pair and sets status bit 7 (NMI-pending). It writes 0x0010 into cause bits [31:16], keeps cause bits [15:0], and jumps to 0x10.
- R6: A non-maskable request seen while `cur_psw` bit 7 is set causes no non-maskable entry and sets the pending flag. Repeated requests are not counted. The flag is taken as one entry at the first later boundary where bit 7 is clear, even if the request line is then low.
- R7: A maskable entry from `mask_req[i]` uses code 0x80 + 0x10*i, so 0x80 for i=0 up to 0xD0 for i=5. It copies `cur_pc` and `cur_psw` into the maskable save pair, writes the code into cause bits [15:0], keeps cause bits [31:16], and jumps to the code.
- R8: Maskable requests are refused while `cur_psw` bit 5 is set. Reset and non-maskable requests ignore that bit.
- R9: Among simultaneous requests, reset wins, then the non-maskable request (when not blocked by bit 7), then the maskable source with the lowest index.
- R10: When no entry is accepted, PC, status word, cause register and save registers hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| insn_done | input | 1 | Instruction boundary strobe |
| reset_req | input | 1 | Reset interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| mask_req | input | 6 | Maskable requests, index 0 highest priority |
| cur_pc | input | 32 | PC of the next instruction at the boundary |
| cur_psw | input | 32 | Current status word |
| new_pc | output | 32 | Entry target PC |
| new_psw | output | 32 | Status word to load on entry |
| ecr | output | 32 | Cause register: [31:16] non-maskable, [15:0] maskable |
| nmi_save_pc | output | 32 | PC saved by non-maskable entry |
| nmi_save_psw | output | 32 | Status saved by non-maskable entry |
| irq_save_pc | output | 32 | PC saved by maskable entry |
| irq_save_psw | output | 32 | Status saved by maskable entry |
| redirect | output | 1 | One-cycle pulse after an accepted entry |

## Verification
The pending flag is the only state that is not visible at the ports. A stuck or lost flag shows up at the next boundary where status bit 7 is clear, as an extra entry to 0x10 or a missing one, so the bench always follows a blocked request with such a boundary. A wrong priority or mask decision shows up in the cycle after the boundary: `redirect`, `new_pc` and the cause half it writes will be wrong. A wrong save-pair selection shows up in that same cycle as a corrupted register in the other pair.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ENT_NONE  = 2'd0,
    ENT_RESET = 2'd1,
    ENT_NMI   = 2'd2,
    ENT_MASK  = 2'd3
  } entry_kind_e;
endpackage

// File: rtl/irq_mask_pick.sv
module irq_mask_pick #(
  parameter int N_SRC = 6,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [IW-1:0]    idx
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_entry_pkg::*;
#(
  parameter int N_SRC = 6,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_done,
  input  logic             reset_req,
  input  logic             nmi_req,
  input  logic [N_SRC-1:0] mask_req,
  input  logic             psw_id,
  input  logic             psw_np,
  output entry_kind_e      kind,
  output logic [IW-1:0]    src_idx,
  output logic             nmi_pend
);
  logic          mask_any;
  logic [IW-1:0] mask_idx;
  logic          pend_q, pend_d;
  logic          nmi_want;

  irq_mask_pick #(.N_SRC(N_SRC)) u_pick (
    .req (mask_req),
    .any (mask_any),
    .idx (mask_idx)
  );

  assign nmi_want = nmi_req | pend_q;
  assign src_idx  = mask_idx;
  assign nmi_pend = pend_q;

  always_comb begin
    kind   = ENT_NONE;
    pend_d = pend_q;
    if (insn_done) begin
      if (reset_req) begin
        kind   = ENT_RESET;
        pend_d = 1'b0;
      end else if (nmi_want && !psw_np) begin
        kind   = ENT_NMI;
        pend_d = 1'b0;
      end else begin
        if (nmi_want) pend_d = 1'b1;
        if (mask_any && !psw_id) kind = ENT_MASK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_d;
  end

  // R6: a blocked non-maskable request leaves the flag set
  a_r6_nmi_latched: assert property (@(posedge clk) disable iff (rst)
    (insn_done && !reset_req && nmi_req && psw_np) |=> pend_q);

  // R9: at most one entry kind, and reset always dominates
  a_r9_reset_first: assert property (@(posedge clk) disable iff (rst)
    (insn_done && reset_req) |-> (kind == ENT_RESET));
endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs
  import irq_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int N_SRC     = 6,
  parameter int ID_BIT    = 5,
  parameter int EP_BIT    = 6,
  parameter int NP_BIT    = 7,
  parameter int RESET_PSW = 'h20,
  parameter int NMI_VEC   = 'h10,
  parameter int NMI_CODE  = 'h10,
  parameter int VEC_BASE  = 'h80,
  parameter int VEC_STEP  = 'h10,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int HALF = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  entry_kind_e     kind,
  input  logic [IW-1:0]   src_idx,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_psw,
  output logic [XLEN-1:0] new_pc,
  output logic [XLEN-1:0] new_psw,
  output logic [XLEN-1:0] ecr,
  output logic [XLEN-1:0] nmi_save_pc,
  output logic [XLEN-1:0] nmi_save_psw,
  output logic [XLEN-1:0] irq_save_pc,
  output logic [XLEN-1:0] irq_save_psw,
  output logic            redirect
);
  localparam logic [XLEN-1:0] ID_M = XLEN'(1) << ID_BIT;
  localparam logic [XLEN-1:0] EP_M = XLEN'(1) << EP_BIT;
  localparam logic [XLEN-1:0] NP_M = XLEN'(1) << NP_BIT;

  logic [XLEN-1:0] mask_code;
  logic [XLEN-1:0] entry_psw;

  assign mask_code = XLEN'(VEC_BASE) + XLEN'(src_idx) * XLEN'(VEC_STEP);
  assign entry_psw = (cur_psw | ID_M) & ~EP_M;

  always_ff @(posedge clk) begin
    if (rst) begin
      new_pc       <= '0;
      new_psw      <= XLEN'(RESET_PSW);
      ecr          <= '0;
      nmi_save_pc  <= '0;
      nmi_save_psw <= '0;
      irq_save_pc  <= '0;
      irq_save_psw <= '0;
      redirect     <= 1'b0;
    end else begin
      redirect <= (kind != ENT_NONE);
      unique case (kind)
        ENT_RESET: begin
          new_pc  <= '0;
          new_psw <= XLEN'(RESET_PSW);
          ecr     <= '0;
        end
        ENT_NMI: begin
          nmi_save_pc  <= cur_pc;
          nmi_save_psw <= cur_psw;
          ecr          <= {HALF'(NMI_CODE), ecr[HALF-1:0]};
          new_psw      <= entry_psw | NP_M;
          new_pc       <= XLEN'(NMI_VEC);
        end
        ENT_MASK: begin
          irq_save_pc  <= cur_pc;
          irq_save_psw <= cur_psw;
          ecr          <= {ecr[XLEN-1:HALF], mask_code[HALF-1:0]};
          new_psw      <= entry_psw;
          new_pc       <= mask_code;
        end
        default: ;
      endcase
    end
  end

  // R3: any redirect presents a masked, non-exception status word
  a_r3_psw_on_entry: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (new_psw[ID_BIT] && !new_psw[EP_BIT]));

  // R7: a maskable target lies on the vector grid and matches the cause
  a_r7_vec_matches_cause: assert property (@(posedge clk) disable iff (rst)
    (kind == ENT_MASK) |=> (new_pc[HALF-1:0] == ecr[HALF-1:0]) && (new_pc >= XLEN'(VEC_BASE)));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int N_SRC     = 6,
  parameter int ID_BIT    = 5,
  parameter int EP_BIT    = 6,
  parameter int NP_BIT    = 7,
  parameter int RESET_PSW = 'h20,
  parameter int NMI_VEC   = 'h10,
  parameter int NMI_CODE  = 'h10,
  parameter int VEC_BASE  = 'h80,
  parameter int VEC_STEP  = 'h10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_done,
  input  logic             reset_req,
  input  logic             nmi_req,
  input  logic [N_SRC-1:0] mask_req,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  cur_psw,
  output logic [XLEN-1:0]  new_pc,
  output logic [XLEN-1:0]  new_psw,
  output logic [XLEN-1:0]  ecr,
  output logic [XLEN-1:0]  nmi_save_pc,
  output logic [XLEN-1:0]  nmi_save_psw,
  output logic [XLEN-1:0]  irq_save_pc,
  output logic [XLEN-1:0]  irq_save_psw,
  output logic             redirect
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  entry_kind_e   kind;
  logic [IW-1:0] src_idx;
  logic          nmi_pend;

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .insn_done (insn_done),
    .reset_req (reset_req),
    .nmi_req   (nmi_req),
    .mask_req  (mask_req),
    .psw_id    (cur_psw[ID_BIT]),
    .psw_np    (cur_psw[NP_BIT]),
    .kind      (kind),
    .src_idx   (src_idx),
    .nmi_pend  (nmi_pend)
  );

  irq_ctx_regs #(
    .XLEN(XLEN), .N_SRC(N_SRC), .ID_BIT(ID_BIT), .EP_BIT(EP_BIT),
    .NP_BIT(NP_BIT), .RESET_PSW(RESET_PSW), .NMI_VEC(NMI_VEC),
    .NMI_CODE(NMI_CODE), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_ctx (
    .clk          (clk),
    .rst          (rst),
    .kind         (kind),
    .src_idx      (src_idx),
    .cur_pc       (cur_pc),
    .cur_psw      (cur_psw),
    .new_pc       (new_pc),
    .new_psw      (new_psw),
    .ecr          (ecr),
    .nmi_save_pc  (nmi_save_pc),
    .nmi_save_psw (nmi_save_psw),
    .irq_save_pc  (irq_save_pc),
    .irq_save_psw (irq_save_psw),
    .redirect     (redirect)
  );

  // R2: a redirect only follows an instruction boundary
  a_r2_redirect_on_boundary: assert property (@(posedge clk) disable iff (rst)
    redirect |-> $past(insn_done));

  // R4: reset request lands at address zero with the reset status
  a_r4_reset_entry: assert property (@(posedge clk) disable iff (rst)
    (insn_done && reset_req) |=> (redirect && new_pc == '0 &&
                                  new_psw == XLEN'(RESET_PSW) && ecr == '0));

  // R5: an unblocked non-maskable request enters at its vector
  a_r5_nmi_entry: assert property (@(posedge clk) disable iff (rst)
    (insn_done && !reset_req && nmi_req && !cur_psw[NP_BIT]) |=>
      (redirect && new_pc == XLEN'(NMI_VEC) && new_psw[NP_BIT]));

  // R8: with interrupts disabled and nothing else pending, no redirect
  a_r8_masked_refused: assert property (@(posedge clk) disable iff (rst)
    (insn_done && cur_psw[ID_BIT] && !reset_req && !nmi_req && !nmi_pend) |=> !redirect);
endmodule

// File: tb/sim_irq_entry_ctrl.sv
`timescale 1ns/100ps
module sim_irq_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst, insn_done, reset_req, nmi_req;
  logic [5:0]  mask_req;
  logic [31:0] cur_pc, cur_psw;
  logic [31:0] new_pc, new_psw, ecr, nsp, nsps, isp, isps;
  logic        redirect;

  always #2.5 clk = ~clk;

  irq_entry_ctrl u0 (
    .clk(clk), .rst(rst), .insn_done(insn_done), .reset_req(reset_req),
    .nmi_req(nmi_req), .mask_req(mask_req), .cur_pc(cur_pc), .cur_psw(cur_psw),
    .new_pc(new_pc), .new_psw(new_psw), .ecr(ecr), .nmi_save_pc(nsp),
    .nmi_save_psw(nsps), .irq_save_pc(isp), .irq_save_psw(isps), .redirect(redirect)
  );

  typedef struct {
    logic        red;
    logic [31:0] pc, psw, ecr, nsp, nsps, isp, isps;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;

  // reference state built from the requirements
  logic [31:0] m_pc, m_psw, m_ecr, m_nsp, m_nsps, m_isp, m_isps;
  logic        m_pend;

  task automatic step(input logic r, input logic d, input logic rq, input logic nm,
                      input logic [5:0] m, input logic [31:0] pc, input logic [31:0] psw,
                      input string tag);
    exp_t e;
    logic red;
    logic nw;
    logic [31:0] code;
    @(negedge clk);
    rst = r; insn_done = d; reset_req = rq; nmi_req = nm;
    mask_req = m; cur_pc = pc; cur_psw = psw;
    red = 1'b0;
    if (r) begin
      m_pc = 0; m_psw = 32'h20; m_ecr = 0; m_nsp = 0; m_nsps = 0;
      m_isp = 0; m_isps = 0; m_pend = 1'b0;
    end else if (d) begin
      nw = nm | m_pend;
      if (rq) begin
        m_pc = 0; m_psw = 32'h20; m_ecr = 0; m_pend = 1'b0; red = 1'b1;
      end else if (nw && !psw[7]) begin
        m_nsp = pc; m_nsps = psw; m_ecr = {16'h0010, m_ecr[15:0]};
        m_psw = (psw | 32'hA0) & ~32'h40; m_pc = 32'h10; m_pend = 1'b0; red = 1'b1;
      end else begin
        if (nw) m_pend = 1'b1;
        if (m != 0 && !psw[5]) begin
          code = 0;
          for (int i = 5; i >= 0; i--) if (m[i]) code = 32'h80 + 32'h10 * i;
          m_isp = pc; m_isps = psw; m_ecr = {m_ecr[31:16], code[15:0]};
          m_psw = (psw | 32'h20) & ~32'h40; m_pc = code; red = 1'b1;
        end
      end
    end
    e.red = red; e.pc = m_pc; e.psw = m_psw; e.ecr = m_ecr; e.nsp = m_nsp;
    e.nsps = m_nsps; e.isp = m_isp; e.isps = m_isps; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare one expected item per cycle, just after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        vectors++;
        if (redirect !== e.red || new_pc !== e.pc || new_psw !== e.psw || ecr !== e.ecr ||
            nsp !== e.nsp || nsps !== e.nsps || isp !== e.isp || isps !== e.isps) begin
          miscompares++;
          $display("FAIL %s: got red=%0b pc=%h psw=%h ecr=%h ns=%h/%h is=%h/%h exp red=%0b pc=%h psw=%h ecr=%h ns=%h/%h is=%h/%h",
                   e.tag, redirect, new_pc, new_psw, ecr, nsp, nsps, isp, isps,
                   e.red, e.pc, e.psw, e.ecr, e.nsp, e.nsps, e.isp, e.isps);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; insn_done = 0; reset_req = 0; nmi_req = 0; mask_req = 0;
    cur_pc = 0; cur_psw = 0;
    step(1, 0, 0, 0, 6'h00, 32'h0, 32'h0, "R1 reset values");
    step(1, 1, 1, 1, 6'h3F, 32'h1234, 32'h0, "R1 reset dominates");
    // R2: no boundary, requests ignored
    step(0, 0, 1, 1, 6'h3F, 32'h1000, 32'h0, "R2 no boundary");
    // R7: single maskable source 2 -> 0xA0
    step(0, 1, 0, 0, 6'h04, 32'h1004, 32'h0000_0041, "R7 source2");
    step(0, 0, 0, 0, 6'h00, 32'h0, 32'h0, "R2 one cycle pulse");
    // R9: sources 1,3,5 -> lowest index 1 wins
    step(0, 1, 0, 0, 6'h2A, 32'h2000, 32'h0, "R9 lowest index");
    step(0, 1, 0, 0, 6'h20, 32'h2004, 32'h0, "R7 source5");
    step(0, 1, 0, 0, 6'h01, 32'h2008, 32'h0, "R7 source0");
    // R8 / R10: masked by ID bit, state holds
    step(0, 1, 0, 0, 6'h3F, 32'h3000, 32'h20, "R8 masked");
    step(0, 0, 0, 0, 6'h00, 32'h0, 32'h0, "R10 hold");
    // R5 + R3: NMI entry, EP cleared, maskable cause half kept
    step(0, 1, 0, 1, 6'h00, 32'h4000, 32'h0000_0060, "R5 nmi entry");
    // R9: NMI beats maskable
    step(0, 1, 0, 1, 6'h01, 32'h4100, 32'h0, "R9 nmi over mask");
    // R9: reset beats NMI
    step(0, 1, 1, 1, 6'h01, 32'h4200, 32'h0, "R9 reset over nmi");
    // R6: NMI while NP set -> pending, counted once
    step(0, 1, 0, 1, 6'h00, 32'h5000, 32'h0000_00A0, "R6 blocked nmi");
    step(0, 1, 0, 1, 6'h00, 32'h5004, 32'h0000_00A0, "R6 second blocked");
    step(0, 1, 0, 0, 6'h00, 32'h5008, 32'h0000_0000, "R6 pending taken");
    step(0, 1, 0, 0, 6'h00, 32'h500C, 32'h0000_0000, "R6 not counted twice");
    // R6: blocked NMI does not stop an eligible maskable request
    step(0, 1, 0, 1, 6'h08, 32'h6000, 32'h0000_0080, "R6 mask while nmi blocked");
    step(0, 1, 0, 0, 6'h00, 32'h6004, 32'h0000_0020, "R6 pending ignores ID");
    // R4: reset request discards pending NMI, saves kept
    step(0, 1, 0, 1, 6'h00, 32'h7000, 32'h0000_0080, "R6 latch again");
    step(0, 1, 1, 0, 6'h00, 32'h7004, 32'h0000_0080, "R4 reset entry");
    step(0, 1, 0, 0, 6'h00, 32'h7008, 32'h0, "R4 pending cleared");
    // R2: back-to-back entries pulse each cycle
    step(0, 1, 0, 0, 6'h10, 32'h8000, 32'h0, "R2 back to back a");
    step(0, 1, 0, 0, 6'h02, 32'h8004, 32'h0, "R2 back to back b");
    step(0, 0, 0, 0, 6'h00, 32'h0, 32'h0, "R2 pulse ends");
    step(0, 0, 0, 0, 6'h00, 32'h0, 32'h0, "R10 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule